// File: doc/BRIEF.md
# Burst Address Counter with Load

This block generates the access address for one port of a synchronous memory. Every clock cycle it picks the address for the current access in one of four ways: it forces it to zero, takes a caller-supplied address, steps the address used in the previous cycle up by one, or repeats that previous address. The chosen address goes out combinationally in the same cycle, so a load, a step or a clear never costs a dead cycle. The same value is captured at the rising edge and becomes the base for the next cycle.

Burst engines use the block this way: they load a start address once and then either step with the counter enable or pause. They can restart the burst at zero at any time. The counter knows nothing about chip or byte enables. Its behaviour depends only on its own three active-low controls.

Top module: `burst_addr_counter`

## Requirements
- R1: After the asynchronous active-low reset `rst_n`, with all three controls high, `access_addr` reads 0.
- R2: When `clear_n` is low, `access_addr` is 0 in that same cycle, and 0 becomes the held address for the next cycle.
- R3: When `clear_n` is high and `load_n` is low, `access_addr` equals `ext_addr` in that same cycle, and that value becomes the held address.
- R4: When `clear_n` and `load_n` are high and `step_n` is low, `access_addr` is the previous cycle's access address plus one, in that same cycle.
- R5: When all three controls are high, `access_addr` repeats the previous cycle's access address, and any value on `ext_addr` has no effect on it.
- R6: `clear_n` low wins over `load_n` low and over `step_n` low.
- R7: `load_n` low wins over `step_n` low.
- R8: A step from the all-ones address (16383 at the default width of 14) gives 0.
- R9: Operations run back to back with no idle cycle between them: a clear, load or step may be followed in the very next cycle by any other operation, and that operation acts on the address just produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ext_addr | input | AW (14) | Caller-supplied address for a load |
| load_n | input | 1 | Active-low address strobe: use `ext_addr` this cycle |
| step_n | input | 1 | Active-low counter enable: previous address plus one |
| clear_n | input | 1 | Active-low counter clear: address 0 this cycle |
| access_addr | output | AW (14) | Address used for the access in the current cycle |

## Verification
The bench builds the block with the default width of 14 bits and two reset-release stages. At this width the wrap from 16383 to 0 can be reached by loading the top address directly, without stepping through the whole space. Each check samples the combinational output within the cycle that has the control pattern under test. This exposes a one-cycle lag anywhere in the load, step or clear paths, as well as any wrong priority between overlapping controls.

// File: rtl/bac_pkg.sv
package bac_pkg;
  typedef enum logic [1:0] {
    CMD_HOLD  = 2'd0,
    CMD_STEP  = 2'd1,
    CMD_LOAD  = 2'd2,
    CMD_CLEAR = 2'd3
  } addr_cmd_e;
endpackage

// File: rtl/bac_reset_sync.sv
module bac_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= 1'b1;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bac_cmd_decode.sv
module bac_cmd_decode
  import bac_pkg::*;
(
  input  logic      clear_n,
  input  logic      load_n,
  input  logic      step_n,
  output addr_cmd_e cmd
);
  // Fixed priority: clear, then load, then step, then hold.
  always_comb begin
    if (!clear_n)     cmd = CMD_CLEAR;
    else if (!load_n) cmd = CMD_LOAD;
    else if (!step_n) cmd = CMD_STEP;
    else              cmd = CMD_HOLD;
  end
endmodule

// File: rtl/bac_next_addr.sv
module bac_next_addr
  import bac_pkg::*;
#(
  parameter int AW = 14
) (
  input  addr_cmd_e       cmd,
  input  logic [AW-1:0]   held_addr,
  input  logic [AW-1:0]   ext_addr,
  output logic [AW-1:0]   cur_addr,
  output logic            wr_en
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  logic [AW-1:0] incr;
  assign incr = held_addr + ONE;  // wraps naturally at the top

  always_comb begin
    unique case (cmd)
      CMD_CLEAR: cur_addr = '0;
      CMD_LOAD:  cur_addr = ext_addr;
      CMD_STEP:  cur_addr = incr;
      default:   cur_addr = held_addr;
    endcase
  end

  // Holding needs no register write.
  assign wr_en = (cmd != CMD_HOLD);
endmodule

// File: rtl/bac_addr_reg.sv
module bac_addr_reg #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] d,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_nxt;

  always_comb begin
    q_nxt = q;
    if (en) q_nxt = d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
  import bac_pkg::*;
#(
  parameter int AW          = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ext_addr,
  input  logic          load_n,
  input  logic          step_n,
  input  logic          clear_n,
  output logic [AW-1:0] access_addr
);
  logic          rst_sync_n;
  addr_cmd_e     cmd;
  logic [AW-1:0] held_q;
  logic [AW-1:0] cur_addr;
  logic          wr_en;

  bac_reset_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bac_cmd_decode u_dec (
    .clear_n (clear_n),
    .load_n  (load_n),
    .step_n  (step_n),
    .cmd     (cmd)
  );

  bac_next_addr #(.AW(AW)) u_nxt (
    .cmd       (cmd),
    .held_addr (held_q),
    .ext_addr  (ext_addr),
    .cur_addr  (cur_addr),
    .wr_en     (wr_en)
  );

  bac_addr_reg #(.AW(AW)) u_reg (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .en    (wr_en),
    .d     (cur_addr),
    .q     (held_q)
  );

  assign access_addr = cur_addr;
endmodule

// File: rtl/bac_checker.sv
module bac_checker #(
  parameter int AW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic [AW-1:0] ext_addr,
  input logic          load_n,
  input logic          step_n,
  input logic          clear_n,
  input logic [AW-1:0] access_addr
);
  localparam logic [AW-1:0] ONE = {{(AW-1){1'b0}}, 1'b1};

  // Set once a full cycle has passed out of reset, so $past is meaningful.
  logic prev_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_ok <= 1'b0;
    else        prev_ok <= 1'b1;
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |-> access_addr == '0);  // R2

  AST_LOAD_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (clear_n && !load_n) |-> access_addr == ext_addr);  // R3

  AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && clear_n && load_n && !step_n) |-> access_addr == ($past(access_addr) + ONE));  // R4

  AST_HOLD_REPEAT: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && clear_n && load_n && step_n) |-> access_addr == $past(access_addr));  // R5

  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_ok && clear_n && load_n && !step_n && $past(access_addr) == '1) |-> access_addr == '0);  // R8
endmodule

bind burst_addr_counter bac_checker #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .ext_addr    (ext_addr),
  .load_n      (load_n),
  .step_n      (step_n),
  .clear_n     (clear_n),
  .access_addr (access_addr)
);

// File: tb/tb_burst_addr_counter.sv
`timescale 1ns/1ps
module tb_burst_addr_counter;
  localparam int AW = 14;
  localparam logic [AW-1:0] TOP = '1;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] ext_addr;
  logic          load_n, step_n, clear_n;
  logic [AW-1:0] access_addr;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  burst_addr_counter #(.AW(AW), .SYNC_STAGES(2)) dut (
    .clk(clk), .rst_n(rst_n), .ext_addr(ext_addr),
    .load_n(load_n), .step_n(step_n), .clear_n(clear_n),
    .access_addr(access_addr)
  );

  task automatic check(input string req, input logic [AW-1:0] exp);
    n_tests++;
    if (access_addr !== exp) begin
      n_fail++;
      $display("FAIL %s: access_addr=%0d expected=%0d", req, access_addr, exp);
    end
  endtask

  // Apply a control pattern for one cycle; output settles 1 ns later.
  task automatic cyc(input logic c, input logic l, input logic s, input logic [AW-1:0] e);
    @(negedge clk);
    clear_n = c; load_n = l; step_n = s; ext_addr = e;
    #1;
  endtask

  task automatic t_reset;
    cyc(1, 1, 1, 14'd777); check("R1 idle after reset", '0);
    cyc(1, 1, 1, 14'd123); check("R1 still zero", '0);
  endtask

  task automatic t_load_hold;
    cyc(1, 0, 1, 14'd4660); check("R3 load same cycle", 14'd4660);
    cyc(1, 1, 1, 14'd99);   check("R3 loaded value held", 14'd4660);
    cyc(1, 1, 1, 14'd5);    check("R5 ext ignored on hold", 14'd4660);
  endtask

  task automatic t_step_run;
    cyc(1, 0, 1, 14'd100); check("R3 load start", 14'd100);
    for (int i = 1; i <= 5; i++) begin
      cyc(1, 1, 0, 14'd3000); check("R4/R9 step back to back", 14'(100 + i));
    end
    cyc(1, 1, 1, 14'd3000); check("R5 pause after steps", 14'd105);
    cyc(1, 1, 0, 14'd0);    check("R4 step after pause", 14'd106);
  endtask

  task automatic t_clear;
    cyc(0, 1, 1, 14'd50); check("R2 clear same cycle", '0);
    cyc(1, 1, 1, 14'd50); check("R2 zero held after clear", '0);
    cyc(0, 1, 1, 14'd0);  check("R2 clear again", '0);
    cyc(1, 1, 0, 14'd0);  check("R9 step right after clear", 14'd1);
  endtask

  task automatic t_priority;
    cyc(1, 0, 1, 14'd900); check("R3 preload", 14'd900);
    cyc(0, 0, 0, 14'd321); check("R6 clear beats load and step", '0);
    cyc(1, 1, 1, 14'd321); check("R6 zero held", '0);
    cyc(1, 0, 0, 14'd2000); check("R7 load beats step", 14'd2000);
    cyc(1, 1, 1, 14'd0);    check("R7 no extra step", 14'd2000);
    cyc(0, 1, 0, 14'd0);    check("R6 clear beats step", '0);
  endtask

  task automatic t_wrap;
    cyc(1, 0, 1, TOP);   check("R8 load top", TOP);
    cyc(1, 1, 0, 14'd7); check("R8 wrap to zero", '0);
    cyc(1, 1, 0, 14'd7); check("R8 continue after wrap", 14'd1);
    cyc(1, 0, 1, 14'd8191); check("R9 load right after step", 14'd8191);
    cyc(1, 1, 0, 14'd0);    check("R9 step right after load", 14'd8192);
  endtask

  initial begin : watchdog
    #50000;
    n_fail++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_addr = '0; load_n = 1'b1; step_n = 1'b1; clear_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_load_hold();
    t_step_run();
    t_clear();
    t_priority();
    t_wrap();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule